// File: doc/BRIEF.md
# CAN Transceiver Digital Supervisor

This block is the digital control behind a high-speed CAN transceiver. It sits between a protocol controller and the analog front end. It has two duties. In active mode it passes the controller's transmit data to the bus driver, and it cuts the drive off when a dominant level lasts too long. That way a stuck controller cannot hold the bus. While the transceiver is disabled, or while the system reset line is asserted, the block listens for a bus wake-up. The wake-up is a dominant, recessive, dominant pattern, each phase filtered for a minimum length, and the whole pattern must arrive within a time window.

The analog driver, the receive comparator, bus biasing and the voltage thresholds all lie outside the block. It only sees the comparator output as a digital level. It drives a select line that chooses between mid-supply bias and ground bias. Every time interval is a parameter counted in clock cycles: the dominant limit `DOM_TO`, the wake phase filter `FILT` (at least 2), the wake window `WAKE_TO` and the listen-to-active delay `MODE_DLY`. All pins are plain level signals with no handshake.

Top module: `cantrx_supervisor`

## Requirements
- R1: In active mode (`bias_mid_o` = 1), `tx_dom_o` is 1 (drive dominant) in the same cycle that `txd_i` is 0, and 0 whenever `txd_i` is 1.
- R2: If `txd_i` stays 0 in active mode, `tx_dom_o` falls to 0 after exactly `DOM_TO` rising clock edges and stays 0 while `txd_i` remains 0.
- R3: After such a cut-off, the drive remains blocked until `txd_i` has been sampled 1 at a clock edge. A 1 that comes and goes between two edges does not release it. Every new low phase is timed from zero.
- R4: When `en_i` = 0 or `sys_rst_n_i` = 0, `tx_dom_o` is 0 at once, whatever `txd_i` is. At the next edge the block is in listen mode, and `bias_mid_o` = 0 selects ground bias.
- R5: In listen mode, `rxd_o` is held at 1 until a wake-up has been recognised. After that it follows `rx_cmp_i`, where 0 means a dominant bus.
- R6: A wake-up is a dominant phase, then a recessive phase, then a dominant phase, each lasting at least `FILT` consecutive clock samples. `wake_o` becomes 1 at the edge that takes the `FILT`-th sample of the last dominant phase.
- R7: A phase shorter than `FILT` samples is ignored and does not move the pattern forward.
- R8: The last phase must qualify no more than `WAKE_TO` edges after the edge at which the first dominant phase qualified. Qualifying exactly on edge `WAKE_TO` still counts. Otherwise the pattern is discarded at that edge, and a later qualifying dominant phase starts a new attempt.
- R9: Once `en_i` and `sys_rst_n_i` are both 1 in listen mode, `bias_mid_o` rises at the (`MODE_DLY`+1)-th edge. If either input drops during the delay, the block returns to listen mode and the full delay starts again on the next attempt.
- R10: In active mode, `rxd_o` equals `rx_cmp_i` in the same cycle.
- R11: `wake_o` stays set until active mode is entered. It clears at the same edge at which `bias_mid_o` rises.
- R12: After `arst_n` is released, the block is in listen mode with `bias_mid_o` = 0, `wake_o` = 0, `tx_dom_o` = 0 and `rxd_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| en_i | input | 1 | Transceiver enable |
| sys_rst_n_i | input | 1 | System reset line, active low; forces listen mode |
| txd_i | input | 1 | Transmit data from controller, 0 = dominant |
| rx_cmp_i | input | 1 | Digitised receive comparator, 0 = dominant |
| tx_dom_o | output | 1 | Driver command, 1 = drive bus dominant |
| rxd_o | output | 1 | Receive data to controller |
| bias_mid_o | output | 1 | 1 = mid-supply bias (active), 0 = ground bias (listen) |
| wake_o | output | 1 | Sticky wake-up flag |

## Verification
Two wake-filter events can fall on the same clock edge: the final dominant phase qualifying, and the overall window running out. The bench makes them meet by giving the recessive phase a length that puts the last dominant qualification exactly on edge `WAKE_TO` of the window. The wake flag must then be set. A run one sample longer must instead discard the attempt, and the late dominant phase must act as the first phase of a new attempt. The bench separately checks that a transmit cut-off is released only by a high level that is sampled at an edge, and not by a pulse between edges.

// File: rtl/cantrx_sup_pkg.sv
package cantrx_sup_pkg;

  typedef enum logic [1:0] {
    MODE_LISTEN = 2'd0,
    MODE_SETTLE = 2'd1,
    MODE_ACTIVE = 2'd2
  } trx_mode_e;

  typedef enum logic [1:0] {
    WK_HUNT    = 2'd0,
    WK_GOT_DOM = 2'd1,
    WK_GOT_REC = 2'd2
  } wk_stage_e;

endpackage

// File: rtl/cantrx_txguard.sv
module cantrx_txguard #(
  parameter int DOM_TO = 40000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic allow_i,
  input  logic txd_i,
  output logic drive_o
);
  localparam int CW = $clog2(DOM_TO + 1);

  logic [CW-1:0] cnt_q;
  logic          blocked_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q     <= '0;
      blocked_q <= 1'b0;
    end else if (txd_i) begin
      cnt_q     <= '0;
      blocked_q <= 1'b0;
    end else if (allow_i && !blocked_q) begin
      if (cnt_q == CW'(DOM_TO - 1)) begin
        blocked_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign drive_o = allow_i & ~txd_i & ~blocked_q;

  assert_block_only_when_low_R2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(blocked_q) |-> $past(allow_i && !txd_i));

  assert_release_after_high_R3: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(blocked_q) |-> $past(txd_i));

endmodule

// File: rtl/cantrx_modectl.sv
module cantrx_modectl
  import cantrx_sup_pkg::*;
#(
  parameter int MODE_DLY = 800
) (
  input  logic      clk,
  input  logic      arst_n,
  input  logic      act_i,
  output trx_mode_e mode_o,
  output logic      enter_o
);
  localparam int DW = $clog2(MODE_DLY + 1);

  trx_mode_e     mode_q, mode_d;
  logic [DW-1:0] cnt_q;
  logic          dly_done;

  assign dly_done = (cnt_q == DW'(MODE_DLY - 1));

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      MODE_LISTEN: if (act_i) mode_d = MODE_SETTLE;
      MODE_SETTLE: begin
        if (!act_i)        mode_d = MODE_LISTEN;
        else if (dly_done) mode_d = MODE_ACTIVE;
      end
      MODE_ACTIVE: if (!act_i) mode_d = MODE_LISTEN;
      default:     mode_d = MODE_LISTEN;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mode_q <= MODE_LISTEN;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= (mode_q == MODE_SETTLE && mode_d == MODE_SETTLE) ? cnt_q + 1'b1 : '0;
    end
  end

  assign mode_o  = mode_q;
  assign enter_o = (mode_q == MODE_SETTLE) && (mode_d == MODE_ACTIVE);

  assert_active_via_settle_R9: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(mode_q == MODE_ACTIVE) |-> $past(mode_q == MODE_SETTLE));

  assert_settle_bounded_R9: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_q == MODE_SETTLE) |-> (cnt_q < DW'(MODE_DLY)));

endmodule

// File: rtl/cantrx_wakefilt.sv
module cantrx_wakefilt
  import cantrx_sup_pkg::*;
#(
  parameter int FILT    = 20,
  parameter int WAKE_TO = 100000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr_i,
  input  logic rx_i,
  output logic wake_o
);
  localparam int RW = $clog2(FILT + 1);
  localparam int TW = $clog2(WAKE_TO + 1);

  wk_stage_e     stage_q;
  logic [RW-1:0] run_q;
  logic [TW-1:0] wt_q;
  logic          lvl_q;
  logic          wake_q;
  logic          same, hit, expire, done;

  assign same   = (rx_i == lvl_q);
  assign hit    = same && (run_q == RW'(FILT - 1));
  assign expire = (stage_q != WK_HUNT) && (wt_q == TW'(WAKE_TO - 1));
  assign done   = (stage_q == WK_GOT_REC) && hit && !rx_i;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= WK_HUNT;
      run_q   <= '0;
      wt_q    <= '0;
      lvl_q   <= 1'b1;
      wake_q  <= 1'b0;
    end else if (clr_i) begin
      stage_q <= WK_HUNT;
      run_q   <= '0;
      wt_q    <= '0;
      lvl_q   <= 1'b1;
      wake_q  <= 1'b0;
    end else begin
      lvl_q <= rx_i;
      if (!same)                     run_q <= RW'(1);
      else if (run_q != RW'(FILT))   run_q <= run_q + 1'b1;

      if (done) begin
        wake_q  <= 1'b1;
        stage_q <= WK_HUNT;
        wt_q    <= '0;
      end else if (expire) begin
        stage_q <= WK_HUNT;
        wt_q    <= '0;
      end else begin
        case (stage_q)
          WK_HUNT: begin
            wt_q <= '0;
            if (hit && !rx_i) stage_q <= WK_GOT_DOM;
          end
          WK_GOT_DOM: begin
            wt_q <= wt_q + 1'b1;
            if (hit && rx_i) stage_q <= WK_GOT_REC;
          end
          WK_GOT_REC: wt_q <= wt_q + 1'b1;
          default:    stage_q <= WK_HUNT;
        endcase
      end
    end
  end

  assign wake_o = wake_q;

  assert_wake_on_dominant_R6: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(wake_q) |-> $past(!rx_i));

  assert_window_bound_R8: assert property (@(posedge clk) disable iff (!arst_n)
    (stage_q != WK_HUNT) |-> (wt_q < TW'(WAKE_TO)));

  assert_wake_sticky_R11: assert property (@(posedge clk) disable iff (!arst_n)
    (wake_q && !clr_i) |=> wake_q);

endmodule

// File: rtl/cantrx_supervisor.sv
module cantrx_supervisor
  import cantrx_sup_pkg::*;
#(
  parameter int DOM_TO   = 40000,
  parameter int FILT     = 20,
  parameter int WAKE_TO  = 100000,
  parameter int MODE_DLY = 800
) (
  input  logic clk,
  input  logic arst_n,
  input  logic en_i,
  input  logic sys_rst_n_i,
  input  logic txd_i,
  input  logic rx_cmp_i,
  output logic tx_dom_o,
  output logic rxd_o,
  output logic bias_mid_o,
  output logic wake_o
);
  trx_mode_e mode;
  logic      act, normal, enter, allow, wake;

  assign act    = en_i & sys_rst_n_i;
  assign normal = (mode == MODE_ACTIVE);
  assign allow  = normal & act;

  cantrx_modectl #(.MODE_DLY(MODE_DLY)) u_mode (
    .clk     (clk),
    .arst_n  (arst_n),
    .act_i   (act),
    .mode_o  (mode),
    .enter_o (enter)
  );

  cantrx_txguard #(.DOM_TO(DOM_TO)) u_tx (
    .clk     (clk),
    .arst_n  (arst_n),
    .allow_i (allow),
    .txd_i   (txd_i),
    .drive_o (tx_dom_o)
  );

  cantrx_wakefilt #(.FILT(FILT), .WAKE_TO(WAKE_TO)) u_wake (
    .clk    (clk),
    .arst_n (arst_n),
    .clr_i  (normal | enter),
    .rx_i   (rx_cmp_i),
    .wake_o (wake)
  );

  assign rxd_o      = (normal | wake) ? rx_cmp_i : 1'b1;
  assign bias_mid_o = normal;
  assign wake_o     = wake;

  assert_no_drive_in_listen_R4: assert property (@(posedge clk) disable iff (!arst_n)
    tx_dom_o |-> bias_mid_o);

  assert_listen_entry_R4: assert property (@(posedge clk) disable iff (!arst_n)
    (!en_i || !sys_rst_n_i) |=> !bias_mid_o);

  assert_rxd_held_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (!bias_mid_o && !wake_o) |-> rxd_o);

  assert_wake_clear_active_R11: assert property (@(posedge clk) disable iff (!arst_n)
    bias_mid_o |-> !wake_o);

endmodule

// File: tb/cantrx_supervisor_test.sv
module cantrx_supervisor_test;
  localparam int DOM_TO   = 20;
  localparam int FILT     = 4;
  localparam int WAKE_TO  = 40;
  localparam int MODE_DLY = 6;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic en_i = 1'b0, sys_rst_n_i = 1'b1, txd_i = 1'b1, rx_cmp_i = 1'b1;
  logic tx_dom_o, rxd_o, bias_mid_o, wake_o;
  int   n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  cantrx_supervisor #(.DOM_TO(DOM_TO), .FILT(FILT), .WAKE_TO(WAKE_TO), .MODE_DLY(MODE_DLY)) uut (
    .clk(clk), .arst_n(arst_n), .en_i(en_i), .sys_rst_n_i(sys_rst_n_i),
    .txd_i(txd_i), .rx_cmp_i(rx_cmp_i), .tx_dom_o(tx_dom_o), .rxd_o(rxd_o),
    .bias_mid_o(bias_mid_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic go_active();
    en_i = 1'b1; sys_rst_n_i = 1'b1;
    tick(MODE_DLY + 1);
  endtask

  task automatic go_listen_clean();
    rx_cmp_i = 1'b1; txd_i = 1'b1;
    go_active();
    en_i = 1'b0;
    tick(1);
  endtask

  task automatic rx_hold(input logic lvl, input int n);
    rx_cmp_i = lvl;
    tick(n);
  endtask

  task automatic t_reset_state();
    #1;
    check("R12 bias", bias_mid_o, 1'b0);
    check("R12 wake", wake_o, 1'b0);
    check("R12 tx", tx_dom_o, 1'b0);
    check("R12 rxd", rxd_o, 1'b1);
  endtask

  task automatic t_mode_delay();
    en_i = 1'b1;
    tick(3);
    en_i = 1'b0;
    tick(1);
    check("R9 abort", bias_mid_o, 1'b0);
    en_i = 1'b1;
    tick(MODE_DLY);
    check("R9 before delay", bias_mid_o, 1'b0);
    tick(1);
    check("R9 after delay", bias_mid_o, 1'b1);
  endtask

  task automatic t_tx_timeout();
    txd_i = 1'b1; #1;
    check("R1 recessive", tx_dom_o, 1'b0);
    txd_i = 1'b0; #1;
    check("R1 dominant", tx_dom_o, 1'b1);
    tick(DOM_TO - 1);
    check("R2 still driving", tx_dom_o, 1'b1);
    tick(1);
    check("R2 cut off", tx_dom_o, 1'b0);
    tick(3);
    check("R2 stays off", tx_dom_o, 1'b0);
  endtask

  task automatic t_tx_release();
    txd_i = 1'b1; #5; txd_i = 1'b0; #1;
    check("R3 unsampled high", tx_dom_o, 1'b0);
    txd_i = 1'b1; tick(1);
    txd_i = 1'b0; #1;
    check("R3 released", tx_dom_o, 1'b1);
    tick(5);
    txd_i = 1'b1; tick(1);
    txd_i = 1'b0;
    tick(DOM_TO - 1);
    check("R3 restart timing", tx_dom_o, 1'b1);
    tick(1);
    check("R3 second cut off", tx_dom_o, 1'b0);
    txd_i = 1'b1; tick(1);
  endtask

  task automatic t_rx_active();
    rx_cmp_i = 1'b0; #1;
    check("R10 rx dominant", rxd_o, 1'b0);
    rx_cmp_i = 1'b1; #1;
    check("R10 rx recessive", rxd_o, 1'b1);
  endtask

  task automatic t_sysreset();
    go_active();
    txd_i = 1'b0; #1;
    check("R4 driving before", tx_dom_o, 1'b1);
    sys_rst_n_i = 1'b0; #1;
    check("R4 tx ignored", tx_dom_o, 1'b0);
    tick(1);
    check("R4 ground bias", bias_mid_o, 1'b0);
    txd_i = 1'b1;
    sys_rst_n_i = 1'b1; en_i = 1'b0;
    tick(1);
  endtask

  task automatic t_wake_basic();
    go_listen_clean();
    txd_i = 1'b0;
    rx_hold(1'b0, 1);
    check("R5 rxd held", rxd_o, 1'b1);
    check("R4 tx in listen", tx_dom_o, 1'b0);
    txd_i = 1'b1;
    tick(FILT - 1);
    rx_hold(1'b1, FILT);
    rx_hold(1'b0, FILT - 1);
    check("R6 not yet", wake_o, 1'b0);
    tick(1);
    check("R6 wake", wake_o, 1'b1);
    check("R5 follows dominant", rxd_o, 1'b0);
    rx_cmp_i = 1'b1; #1;
    check("R5 follows recessive", rxd_o, 1'b1);
  endtask

  task automatic t_wake_clear();
    en_i = 1'b1;
    tick(MODE_DLY);
    check("R11 sticky in settle", wake_o, 1'b1);
    tick(1);
    check("R11 cleared", wake_o, 1'b0);
    check("R11 bias up", bias_mid_o, 1'b1);
  endtask

  task automatic t_wake_glitch();
    go_listen_clean();
    rx_hold(1'b0, FILT - 1);
    rx_hold(1'b1, FILT);
    rx_hold(1'b0, FILT);
    check("R7 glitch ignored", wake_o, 1'b0);
    rx_hold(1'b1, FILT);
    rx_hold(1'b0, FILT - 1);
    check("R7 still waiting", wake_o, 1'b0);
    tick(1);
    check("R7 wake after valid", wake_o, 1'b1);
  endtask

  task automatic t_window_edge();
    go_listen_clean();
    rx_hold(1'b0, FILT);
    rx_hold(1'b1, WAKE_TO - FILT);
    rx_hold(1'b0, FILT);
    check("R8 completes on last edge", wake_o, 1'b1);
  endtask

  task automatic t_window_late();
    go_listen_clean();
    rx_hold(1'b0, FILT);
    rx_hold(1'b1, WAKE_TO - FILT + 1);
    rx_hold(1'b0, FILT);
    check("R8 late pattern rejected", wake_o, 1'b0);
    rx_hold(1'b1, FILT);
    rx_hold(1'b0, FILT);
    check("R8 restart counted", wake_o, 1'b1);
  endtask

  initial begin
    t_reset_state();
    #50 arst_n = 1'b1;
    tick(2);
    t_reset_state();
    t_mode_delay();
    t_tx_timeout();
    t_tx_release();
    t_rx_active();
    t_sysreset();
    t_wake_basic();
    t_wake_clear();
    t_wake_glitch();
    t_window_edge();
    t_window_late();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule